// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single control words between two independently clocked ports, and the words never enter the data queue. The first mail word is loaded from port A and picked up on port B. The second is loaded from port B and picked up on port A. Each word has an active-low occupancy flag, which is synchronous to the clock of the loading side. The flag works as the write-side ready signal. While it is high, the port may load a word. Once a word is accepted, the flag drops and stays low until the far side has taken the word.

Each port has a mailbox select pin. When it is high, a transfer is steered to the mail register. When it is low, the transfer goes to the queue, which lives outside this block. On the read path the same pin chooses what drives the port's output: the mail register, or the queue output word that is fed in from outside. A static bus-size input sets the usable width of both mail registers to 36, 18 or 9 bits.

Load and pick-up events cross between the clock domains as toggles, each through a two-flop synchronizer. Back-pressure is the flag alone: a load attempt made while the flag is low is dropped, and the port is not stalled.

Top module: `mbx_pair`

## Requirements
- R1: After reset both occupancy flags are high, and either port reading with its mailbox select high sees an all-zero word.
- R2: A port A load (a_en=1, a_wr=1, a_mbx=1) on a clock A edge where mb1_full_n is high stores the word, and mb1_full_n is low from that edge on.
- R3: A load made while the target flag is low leaves the stored word unchanged.
- R4: A port B pick-up (b_en=1, b_wr=0, b_mbx=1) made at least two clock B edges after the load presents the stored word on b_dout. mb1_full_n stays low across the first clock A edge after the pick-up and is high again by the fourth.
- R5: Mirror path: a port B load sets mb2_full_n low (clock B domain). Port A pick-up (a_en=1, a_wr=0, a_mbx=1) presents the word on a_dout and frees mb2_full_n within four clock B edges.
- R6: Transfers with the mailbox select low leave both flags and both mail words unchanged.
- R7: With the mailbox select low, a port's output equals its queue-output input word.
- R8: bus_size encoding: 0 selects 36 bits, 1 selects 18 bits (bits 0..17), 2 or 3 selects 9 bits (bits 0..8). Input bits above the selected width are dropped on load.
- R9: Mailbox output bits above the selected width are zero.
- R10: A load presented on the same edge at which the flag is released is ignored. Only a load on a later edge, after the flag reads high, is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| bus_size | input | 2 | Usable width select (static) |
| a_en | input | 1 | Port A transfer enable (select and enable combined) |
| a_wr | input | 1 | Port A direction, 1 = load |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A input word |
| a_fifo_q | input | 36 | Queue output word for port A |
| a_dout | output | 36 | Port A output word |
| mb1_full_n | output | 1 | First mail word flag, low = occupied (clock A) |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction, 1 = load |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B input word |
| b_fifo_q | input | 36 | Queue output word for port B |
| b_dout | output | 36 | Port B output word |
| mb2_full_n | output | 1 | Second mail word flag, low = occupied (clock B) |

## Verification
Two events can land on the same loading-side edge: the flag release coming back from the far domain, and a new load attempt from the local port. The bench provokes this by holding a load request active and changing its data word on every cycle while the release is travelling back. The expected stored word is the one presented on the first edge after the flag was seen high at a falling clock edge. The bench checks this with a later pick-up, and it also checks that no word presented on or before the release edge was stored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_W = 36;
  localparam int HALF_W = MBX_W / 2;
  localparam int QUART_W = MBX_W / 4;

  typedef enum logic [1:0] {
    BUS_FULL = 2'd0,
    BUS_HALF = 2'd1,
    BUS_QUART = 2'd2,
    BUS_QUART_ALT = 2'd3
  } bus_size_e;

  function automatic logic [MBX_W-1:0] lane_mask(input logic [1:0] sz);
    logic [MBX_W-1:0] m;
    case (bus_size_e'(sz))
      BUS_FULL: m = '1;
      BUS_HALF: m = {{(MBX_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default:  m = {{(MBX_W-QUART_W){1'b0}}, {QUART_W{1'b1}}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int W = 36
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  input  logic         rd_req,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mail_q;
  logic         load_tog;
  logic         ack_tog;
  logic         ack_sync;
  logic         ack_seen;
  logic         load_sync;
  logic         load_seen;
  logic         pending;
  logic         release_now;

  // write-side: flag, storage, load toggle
  mbx_sync2 #(.W(1)) u_ack_sync (
    .clk(wclk), .rst_n(rst_n), .d(ack_tog), .q(ack_sync)
  );

  assign release_now = (ack_sync != ack_seen);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      mail_q   <= '0;
      full_n   <= 1'b1;
      load_tog <= 1'b0;
      ack_seen <= 1'b0;
    end else if (release_now) begin
      ack_seen <= ack_sync;
      full_n   <= 1'b1;
    end else if (wr_req && full_n) begin
      mail_q   <= wdata;
      full_n   <= 1'b0;
      load_tog <= ~load_tog;
    end
  end

  // read-side: see the load, acknowledge a pick-up
  mbx_sync2 #(.W(1)) u_load_sync (
    .clk(rclk), .rst_n(rst_n), .d(load_tog), .q(load_sync)
  );

  assign pending = (load_sync != load_seen);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      load_seen <= 1'b0;
      ack_tog   <= 1'b0;
    end else if (rd_req && pending) begin
      load_seen <= load_sync;
      ack_tog   <= ~ack_tog;
    end
  end

  // word is held stable while the flag is low, so the far side reads it directly
  assign rdata = mail_q;

  assert_load_lowers_flag_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && full_n) |=> !full_n);

  assert_locked_word_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(mail_q));

  assert_release_beats_load_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    (release_now && wr_req) |=> ($stable(mail_q) && full_n));

  assert_pickup_consumes_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && pending) |=> !pending);
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
(
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic [1:0]       bus_size,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic             a_mbx,
  input  logic [MBX_W-1:0] a_din,
  input  logic [MBX_W-1:0] a_fifo_q,
  output logic [MBX_W-1:0] a_dout,
  output logic             mb1_full_n,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic             b_mbx,
  input  logic [MBX_W-1:0] b_din,
  input  logic [MBX_W-1:0] b_fifo_q,
  output logic [MBX_W-1:0] b_dout,
  output logic             mb2_full_n
);
  logic [MBX_W-1:0] lanes;
  logic [MBX_W-1:0] mail1_w;
  logic [MBX_W-1:0] mail2_w;
  logic             a_load, a_pick, b_load, b_pick;

  assign lanes  = lane_mask(bus_size);
  assign a_load = a_en &  a_wr & a_mbx;
  assign a_pick = a_en & ~a_wr & a_mbx;
  assign b_load = b_en &  b_wr & b_mbx;
  assign b_pick = b_en & ~b_wr & b_mbx;

  mbx_channel #(.W(MBX_W)) u_a_to_b (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
    .wr_req(a_load), .wdata(a_din & lanes), .full_n(mb1_full_n),
    .rd_req(b_pick), .rdata(mail1_w)
  );

  mbx_channel #(.W(MBX_W)) u_b_to_a (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
    .wr_req(b_load), .wdata(b_din & lanes), .full_n(mb2_full_n),
    .rd_req(a_pick), .rdata(mail2_w)
  );

  assign a_dout = a_mbx ? (mail2_w & lanes) : a_fifo_q;
  assign b_dout = b_mbx ? (mail1_w & lanes) : b_fifo_q;

  assert_queue_load_keeps_flag_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_en && a_wr && !a_mbx && mb1_full_n) |=> mb1_full_n);
endmodule

// File: tb/mbx_pair_test.sv
module mbx_pair_test;
  logic        clk_a = 0, clk_b = 0, rst_n = 0;
  logic [1:0]  bus_size = 0;
  logic        a_en = 0, a_wr = 0, a_mbx = 0, b_en = 0, b_wr = 0, b_mbx = 0;
  logic [35:0] a_din = 0, a_fifo_q = 0, b_din = 0, b_fifo_q = 0;
  logic [35:0] a_dout, b_dout;
  logic        mb1_full_n, mb2_full_n;
  int          checks = 0, errors = 0;
  logic [35:0] exp1 = 0, exp2 = 0;

  mbx_pair uut (.*);

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  function automatic logic [35:0] width_of(input logic [1:0] sz);
    if (sz == 2'd0) return {36{1'b1}};
    if (sz == 2'd1) return {18'd0, {18{1'b1}}};
    return {27'd0, {9{1'b1}}};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // port A loads the first mail word
  task automatic a_load(input logic mbx, input logic [35:0] d);
    @(negedge clk_a); a_en = 1; a_wr = 1; a_mbx = mbx; a_din = d;
    @(negedge clk_a); a_en = 0; a_wr = 0; a_mbx = 0;
  endtask

  task automatic b_load(input logic mbx, input logic [35:0] d);
    @(negedge clk_b); b_en = 1; b_wr = 1; b_mbx = mbx; b_din = d;
    @(negedge clk_b); b_en = 0; b_wr = 0; b_mbx = 0;
  endtask

  // port B pick-up of first word; R4 data and timing, R9 upper zeros
  task automatic b_pick(input bit race);
    bit seen = 0;
    logic [35:0] v;
    repeat (3) @(negedge clk_b);
    b_en = 1; b_wr = 0; b_mbx = 1; #1;
    chk("R4/R9 b_dout pick", b_dout, exp1);
    @(negedge clk_b); b_en = 0; b_mbx = 0;
    @(negedge clk_a);
    chk("R4 flag still low", {35'd0, mb1_full_n}, 36'd0);
    if (race) begin
      // R10: keep loading junk while the release travels back
      a_en = 1; a_wr = 1; a_mbx = 1; a_din = {$urandom, $urandom};
      for (int i = 0; i < 6 && !seen; i++) begin
        @(negedge clk_a);
        if (mb1_full_n) seen = 1;
        else a_din = {$urandom, $urandom};
      end
      v = {$urandom, $urandom};
      a_din = v;
      @(negedge clk_a); a_en = 0; a_wr = 0; a_mbx = 0;
      chk("R10 release seen", {35'd0, seen}, 36'd1);
      chk("R10 load after release lowers flag", {35'd0, mb1_full_n}, 36'd0);
      exp1 = v & width_of(bus_size);
    end else begin
      for (int i = 0; i < 4 && !seen; i++) begin
        @(negedge clk_a);
        if (mb1_full_n) seen = 1;
      end
      chk("R4 flag released", {35'd0, seen}, 36'd1);
    end
  endtask

  task automatic a_pick();
    bit seen = 0;
    repeat (3) @(negedge clk_a);
    a_en = 1; a_wr = 0; a_mbx = 1; #1;
    chk("R5/R9 a_dout pick", a_dout, exp2);
    @(negedge clk_a); a_en = 0; a_mbx = 0;
    for (int i = 0; i < 5 && !seen; i++) begin
      @(negedge clk_b);
      if (mb2_full_n) seen = 1;
    end
    chk("R5 flag released", {35'd0, seen}, 36'd1);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    #33 rst_n = 1;
    @(negedge clk_a);
    a_mbx = 1; b_mbx = 1; #1;
    chk("R1 flag1", {35'd0, mb1_full_n}, 36'd1);
    chk("R1 flag2", {35'd0, mb2_full_n}, 36'd1);
    chk("R1 a_dout zero", a_dout, 36'd0);
    chk("R1 b_dout zero", b_dout, 36'd0);
    a_mbx = 0; b_mbx = 0;

    // R2, R3 directed
    a_load(1, 36'h123456789);
    exp1 = 36'h123456789;
    chk("R2 flag low", {35'd0, mb1_full_n}, 36'd0);
    a_load(1, 36'hFEDCBA987);
    chk("R3 flag stays low", {35'd0, mb1_full_n}, 36'd0);
    b_pick(0);

    // R8/R9 at 9-bit width
    bus_size = 2'd2;
    a_load(1, {36{1'b1}});
    exp1 = 36'h1FF;
    b_pick(0);
    bus_size = 2'd1;
    b_load(1, {36{1'b1}});
    exp2 = 36'h3FFFF;
    chk("R5 flag2 low", {35'd0, mb2_full_n}, 36'd0);
    a_pick();

    // R6, R7: queue path
    bus_size = 2'd0;
    a_load(0, 36'hABCDE0123);
    chk("R6 flag1 untouched", {35'd0, mb1_full_n}, 36'd1);
    b_load(0, 36'h555555555);
    chk("R6 flag2 untouched", {35'd0, mb2_full_n}, 36'd1);
    b_fifo_q = 36'h0DEADBEEF; a_fifo_q = 36'h876543210; #1;
    chk("R7 a_dout queue", a_dout, a_fifo_q);
    chk("R7 b_dout queue", b_dout, b_fifo_q);

    // R10 directed race, then random mix
    a_load(1, 36'h111111111);
    exp1 = 36'h111111111;
    b_pick(1);
    b_pick(0);
    for (int n = 0; n < 30; n++) begin
      logic [35:0] d;
      bus_size = 2'($urandom_range(0, 3));
      d = {$urandom, $urandom};
      case ($urandom_range(0, 2))
        0: begin
          a_load(1, d); exp1 = d & width_of(bus_size);
          chk("R2 flag low rnd", {35'd0, mb1_full_n}, 36'd0);
          if ($urandom_range(0, 1)) a_load(1, ~d);
          b_pick($urandom_range(0, 1) == 1);
          if (!mb1_full_n) b_pick(0);
        end
        1: begin
          b_load(1, d); exp2 = d & width_of(bus_size);
          chk("R5 flag2 low rnd", {35'd0, mb2_full_n}, 36'd0);
          a_pick();
        end
        default: begin
          @(negedge clk_a);
          a_fifo_q = d; b_fifo_q = ~d; #1;
          chk("R7 a_dout queue rnd", a_dout, d);
          chk("R7 b_dout queue rnd", b_dout, ~d);
        end
      endcase
    end
    summary();
  end
endmodule